// File: doc/BRIEF.md
# Scanline Tile Fetch and Render Sequencer

This block produces the horizontal timing for a tile-based display that has no memory of its own. It shares the host CPU's memory by asking for the CPU bus during a fixed part of each line. It counts pixel clocks along a 288-pixel line and counts lines across the frame. On visible lines with rendering enabled, it raises a bus request. Once the CPU grants the bus, it walks a fixed access pattern. The pattern is one tile-number read followed by three bitplane reads, and it repeats every 8 pixels.

The three bytes of each group are loaded into shift registers. They come out as 3-bit colour pixels, starting a fixed number of pixels after the group's tile read. The sequencer gives the bus back before the last group has been drawn, and it finishes that sliver from the bytes it already holds. If rendering is enabled in the middle of a line, the first one or two slivers come from stale held bytes. Later slivers are correct.

Top module: `tile_scan_render`

## Requirements
- R1: A line is 288 pixel clocks long, and pixel 0 is the first pixel of horizontal sync. `hsync_o` is high for pixels 0 through 21 and low for the rest of the line. Pixel and line counters reset to 0.
- R2: Bus requests, memory strobes and drawn pixels occur only on visible lines (lines 0 to ACTIVE_LINES-1) and only while `render_en_i` is 1. Otherwise `busreq_o`, `mreq_o`, `addr_o` and `pix_o` are all 0.
- R3: On a visible line with rendering enabled, `busreq_o` is 1 for pixels 20 through 267 inclusive and 0 for the other 40 pixels.
- R4: `mreq_o` is 1 exactly while `busack_i` and `busreq_o` are both 1.
- R5: Starting at pixel 28, accesses last 2 pixels each, and each access holds its address for both pixels. The accesses repeat in the order tile number, plane 0, plane 1, plane 2. Read data is taken on the second pixel of each access. Groups start every 8 pixels, and the last group starts at pixel 260.
- R6: The tile-number address is 0xB800 + 0x20 × (line / 8) + coarse X. Coarse X is 0 for the group at pixel 28 and rises by 1 per group. So pixel 44 reads base+2 and pixel 260 reads base+0x1D.
- R7: The address for plane k (k = 0, 1, 2) is pattern base (0x0000) + 8 × tile number + (line mod 8) + k × 0x800. The tile number is the byte read in the same group.
- R8: A group whose tile access starts at pixel s is drawn at pixels s+10 through s+17, most significant bit first. `pix_o[k]` carries the bit of plane k.
- R9: The group fetched at pixel 260 is drawn at pixels 270 to 277 after the bus has been released. `pix_o` is 0 from pixel 278 to the end of the line and from pixel 0 to pixel 37.
- R10: If `render_en_i` rises at pixel 99 of a visible line, the bus request starts at once. Groups whose tile access starts after the grant are drawn correctly, from pixel 118 to the end of the window.
- R11: When `mreq_o` is 0, `addr_o` is 0. If no grant arrives, nothing is captured and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| render_en_i | input | 1 | Rendering enable configuration bit |
| busack_i | input | 1 | Bus grant from the CPU |
| rd_data_i | input | 8 | Memory read data |
| busreq_o | output | 1 | Bus request to the CPU |
| mreq_o | output | 1 | Memory request strobe |
| addr_o | output | 16 | Memory address |
| hsync_o | output | 1 | Horizontal sync |
| pix_o | output | 3 | Pixel colour, bit k from plane k |

## Verification
The assertions assume that `busack_i` is raised only in answer to `busreq_o` and drops once the request falls. They also assume that `rd_data_i` is a combinational function of `addr_o` that settles within the same pixel. The bench's grant model follows `busreq_o` on the falling clock edge and models memory as a fixed function of the address. Enable and grant changes are applied between edges, away from both the sampling point and the grant model's update.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int NPLANES  = 3;
  localparam int PLANE_W  = 8;
  localparam int GROUP_PX = 8;

  typedef enum logic [1:0] {
    SLOT_MAP = 2'd0,
    SLOT_P0  = 2'd1,
    SLOT_P1  = 2'd2,
    SLOT_P2  = 2'd3
  } slot_e;

  typedef logic [NPLANES-1:0][PLANE_W-1:0] planes_t;
endpackage

// File: rtl/tsr_timing.sv
module tsr_timing #(
  parameter int LINE_PIXELS  = 288,
  parameter int TOTAL_LINES  = 262,
  parameter int ACTIVE_LINES = 192,
  parameter int HSYNC_PIXELS = 22,
  parameter int REQ_FIRST    = 20,
  parameter int REQ_LAST     = 267,
  parameter int PXW          = $clog2(LINE_PIXELS),
  parameter int LNW          = $clog2(TOTAL_LINES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  output logic [PXW-1:0] px_o,
  output logic [LNW-1:0] line_o,
  output logic           show_o,
  output logic           hsync_o,
  output logic           busreq_o
);
  localparam logic [PXW-1:0] PX_LAST = PXW'(LINE_PIXELS - 1);
  localparam logic [PXW-1:0] PX_HS   = PXW'(HSYNC_PIXELS);
  localparam logic [PXW-1:0] PX_RF   = PXW'(REQ_FIRST);
  localparam logic [PXW-1:0] PX_RL   = PXW'(REQ_LAST);
  localparam logic [LNW-1:0] LN_LAST = LNW'(TOTAL_LINES - 1);
  localparam logic [LNW-1:0] LN_ACT  = LNW'(ACTIVE_LINES);

  logic [PXW-1:0] px_q;
  logic [LNW-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_q   <= '0;
      line_q <= '0;
    end else if (px_q == PX_LAST) begin
      px_q   <= '0;
      line_q <= (line_q == LN_LAST) ? '0 : line_q + 1'b1;
    end else begin
      px_q <= px_q + 1'b1;
    end
  end

  assign px_o     = px_q;
  assign line_o   = line_q;
  assign show_o   = en_i && (line_q < LN_ACT);
  assign hsync_o  = px_q < PX_HS;
  assign busreq_o = show_o && (px_q >= PX_RF) && (px_q <= PX_RL);

  a_r1_px_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (px_q == PX_LAST) |=> (px_q == '0));

  a_r3_req_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (px_q == PX_RL) |=> !busreq_o);
endmodule

// File: rtl/tsr_fetch.sv
module tsr_fetch
  import tsr_pkg::*;
#(
  parameter int             PXW          = 9,
  parameter int             LNW          = 9,
  parameter int             AW           = 16,
  parameter int             FETCH_FIRST  = 28,
  parameter int             REQ_LAST     = 267,
  parameter int             MAP_STRIDE   = 32,
  parameter logic [AW-1:0]  MAP_BASE     = 16'hB800,
  parameter logic [AW-1:0]  PAT_BASE     = 16'h0000,
  parameter logic [AW-1:0]  PLANE_STRIDE = 16'h0800
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PXW-1:0]     px_i,
  input  logic [LNW-1:0]     line_i,
  input  logic               busreq_i,
  input  logic               busack_i,
  input  logic [PLANE_W-1:0] rd_i,
  output logic               mreq_o,
  output logic [AW-1:0]      addr_o,
  output planes_t            planes_o
);
  localparam logic [PXW-1:0] PX_FF = PXW'(FETCH_FIRST);
  localparam logic [PXW-1:0] PX_FL = PXW'(REQ_LAST);

  logic [PXW-1:0]     rel;
  logic               in_fetch;
  logic               cap;
  slot_e              slot;
  logic [PXW-4:0]     grp;
  logic [1:0]         plane_idx;
  logic [PLANE_W-1:0] tile_q;
  planes_t            planes_q;

  assign rel       = px_i - PX_FF;
  assign in_fetch  = (px_i >= PX_FF) && (px_i <= PX_FL);
  assign slot      = slot_e'(rel[2:1]);
  assign grp       = rel[PXW-1:3];
  assign plane_idx = rel[2:1] - 2'd1;
  assign mreq_o    = busack_i && busreq_i;
  assign cap       = mreq_o && in_fetch && rel[0];

  always_comb begin
    addr_o = '0;
    if (mreq_o && in_fetch) begin
      if (slot == SLOT_MAP)
        addr_o = MAP_BASE + AW'(line_i[LNW-1:3]) * AW'(MAP_STRIDE) + AW'(grp);
      else
        addr_o = PAT_BASE + AW'({tile_q, 3'b000}) + AW'(line_i[2:0])
               + AW'(plane_idx) * PLANE_STRIDE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tile_q <= '0;
    else if (cap && slot == SLOT_MAP)   tile_q <= rd_i;
  end

  for (genvar k = 0; k < NPLANES; k++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                planes_q[k] <= '0;
      else if (cap && rel[2:1] == 2'(k + 1))      planes_q[k] <= rd_i;
    end
  end

  assign planes_o = planes_q;

  // each access keeps its address for both of its pixels
  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_o && in_fetch && !rel[0]) |=> (!mreq_o || $stable(addr_o)));

  a_r11_addr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mreq_o |-> (addr_o == '0));
endmodule

// File: rtl/tsr_shifter.sv
module tsr_shifter
  import tsr_pkg::*;
#(
  parameter int PXW        = 9,
  parameter int DRAW_FIRST = 38,
  parameter int NGROUPS    = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PXW-1:0]     px_i,
  input  planes_t            planes_i,
  output logic [NPLANES-1:0] bits_o
);
  localparam logic [PXW-1:0] PX_L0 = PXW'(DRAW_FIRST - 1);
  localparam logic [PXW-1:0] PX_LN = PXW'(DRAW_FIRST - 1 + GROUP_PX * (NGROUPS - 1));

  logic [PXW-1:0] rel;
  logic           load;
  planes_t        sh_q;

  assign rel  = px_i - PX_L0;
  assign load = (px_i >= PX_L0) && (px_i <= PX_LN) && (rel[2:0] == 3'd0);

  for (genvar k = 0; k < NPLANES; k++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   sh_q[k] <= '0;
      else if (load) sh_q[k] <= planes_i[k];
      else           sh_q[k] <= {sh_q[k][PLANE_W-2:0], 1'b0};
    end
    assign bits_o[k] = sh_q[k][PLANE_W-1];
  end

  a_r8_load_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !load);
endmodule

// File: rtl/tile_scan_render.sv
module tile_scan_render
  import tsr_pkg::*;
#(
  parameter int            LINE_PIXELS  = 288,
  parameter int            TOTAL_LINES  = 262,
  parameter int            ACTIVE_LINES = 192,
  parameter int            HSYNC_PIXELS = 22,
  parameter int            REQ_FIRST    = 20,
  parameter int            REQ_LAST     = 267,
  parameter int            FETCH_FIRST  = 28,
  parameter int            DRAW_LAG     = 10,
  parameter int            AW           = 16,
  parameter int            MAP_STRIDE   = 32,
  parameter logic [AW-1:0] MAP_BASE     = 16'hB800,
  parameter logic [AW-1:0] PAT_BASE     = 16'h0000,
  parameter logic [AW-1:0] PLANE_STRIDE = 16'h0800
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               render_en_i,
  input  logic               busack_i,
  input  logic [PLANE_W-1:0] rd_data_i,
  output logic               busreq_o,
  output logic               mreq_o,
  output logic [AW-1:0]      addr_o,
  output logic               hsync_o,
  output logic [NPLANES-1:0] pix_o
);
  localparam int PXW        = $clog2(LINE_PIXELS);
  localparam int LNW        = $clog2(TOTAL_LINES);
  localparam int NGROUPS    = (REQ_LAST + 1 - FETCH_FIRST) / GROUP_PX;
  localparam int DRAW_FIRST = FETCH_FIRST + DRAW_LAG;
  localparam int DRAW_LAST  = DRAW_FIRST + GROUP_PX * NGROUPS - 1;
  localparam logic [PXW-1:0] PX_DF = PXW'(DRAW_FIRST);
  localparam logic [PXW-1:0] PX_DL = PXW'(DRAW_LAST);

  logic [PXW-1:0]     px;
  logic [LNW-1:0]     line;
  logic               show;
  logic               draw_win;
  planes_t            planes;
  logic [NPLANES-1:0] bits;

  tsr_timing #(
    .LINE_PIXELS (LINE_PIXELS),
    .TOTAL_LINES (TOTAL_LINES),
    .ACTIVE_LINES(ACTIVE_LINES),
    .HSYNC_PIXELS(HSYNC_PIXELS),
    .REQ_FIRST   (REQ_FIRST),
    .REQ_LAST    (REQ_LAST),
    .PXW         (PXW),
    .LNW         (LNW)
  ) i_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (render_en_i),
    .px_o    (px),
    .line_o  (line),
    .show_o  (show),
    .hsync_o (hsync_o),
    .busreq_o(busreq_o)
  );

  tsr_fetch #(
    .PXW         (PXW),
    .LNW         (LNW),
    .AW          (AW),
    .FETCH_FIRST (FETCH_FIRST),
    .REQ_LAST    (REQ_LAST),
    .MAP_STRIDE  (MAP_STRIDE),
    .MAP_BASE    (MAP_BASE),
    .PAT_BASE    (PAT_BASE),
    .PLANE_STRIDE(PLANE_STRIDE)
  ) i_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .px_i    (px),
    .line_i  (line),
    .busreq_i(busreq_o),
    .busack_i(busack_i),
    .rd_i    (rd_data_i),
    .mreq_o  (mreq_o),
    .addr_o  (addr_o),
    .planes_o(planes)
  );

  tsr_shifter #(
    .PXW       (PXW),
    .DRAW_FIRST(DRAW_FIRST),
    .NGROUPS   (NGROUPS)
  ) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .px_i    (px),
    .planes_i(planes),
    .bits_o  (bits)
  );

  assign draw_win = show && (px >= PX_DF) && (px <= PX_DL);
  assign pix_o    = draw_win ? bits : '0;

  a_r2_dark_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !render_en_i |-> (pix_o == '0 && !busreq_o));

  a_r9_dark_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (px > PX_DL) |-> (pix_o == '0));

  a_r4_strobe_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_o |-> (hsync_o == (px < PXW'(HSYNC_PIXELS))) && busreq_o);
endmodule

// File: tb/test_tile_scan_render.sv
`timescale 1ns/100ps
module test_tile_scan_render;
  localparam int LP = 288;
  localparam int TL = 12;
  localparam int AL = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        grant = 1'b0;
  logic        busack = 1'b0;
  logic [7:0]  rd;
  logic        busreq, mreq, hsync;
  logic [15:0] addr;
  logic [2:0]  pix;

  int total = 0;
  int bad = 0;
  int cnt = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem(input int a);
    if (a >= 'hB800) return 8'((a % 32) * 7 + ((a / 32) % 32) * 3 + 1);
    return 8'((a * 29) ^ (a / 256) ^ 'h5A);
  endfunction

  assign rd = mem(int'(addr));

  always @(negedge clk) busack <= grant & busreq;

  always @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else        cnt <= cnt + 1;
  end

  tile_scan_render #(.TOTAL_LINES(TL), .ACTIVE_LINES(AL)) i_tile_scan_render (
    .clk_i(clk), .rst_ni(rst_n), .render_en_i(en), .busack_i(busack),
    .rd_data_i(rd), .busreq_o(busreq), .mreq_o(mreq), .addr_o(addr),
    .hsync_o(hsync), .pix_o(pix)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int map_addr(input int line, input int g);
    return 'hB800 + (line / 8) * 32 + g;
  endfunction

  function automatic int exp_addr(input int line, input int px);
    int rel = px - 28;
    int slot = (rel / 2) % 4;
    int tile = mem(map_addr(line, rel / 8));
    if (slot == 0) return map_addr(line, rel / 8);
    return tile * 8 + line % 8 + (slot - 1) * 'h800;
  endfunction

  function automatic int exp_pix(input int line, input int px);
    int g = (px - 38) / 8;
    int b = 7 - (px - 38) % 8;
    int tile = mem(map_addr(line, g));
    int v = 0;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] by = mem(tile * 8 + line % 8 + k * 'h800);
      v |= int'(by[b]) << k;
    end
    return v;
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
    #1;
  endtask

  task automatic goto(input int line);
    while (!((cnt % LP) == 0 && ((cnt / LP) % TL) == line)) step();
  endtask

  // walks one line; enable takes effect from en_from, strobe from ack_from,
  // pixels compared from pix_from on
  task automatic walk(input int line, input int en_from, input int ack_from,
                      input int pix_from, input string ptag);
    for (int px = 0; px < LP; px++) begin
      bit on, req, strobe;
      string rtag;
      if (px > 0) begin
        @(negedge clk);
        #1;
        if (px == en_from) en = 1'b1;
        #1;
      end
      on     = (px >= en_from) && (line < AL);
      req    = on && px >= 20 && px <= 267;
      strobe = req && px >= ack_from;
      rtag   = (line >= AL || en_from >= LP) ? "R2" : "R3";
      chk("R1", "hsync", int'(hsync), int'(px < 22));
      chk(rtag, "busreq", int'(busreq), int'(req));
      chk("R4", "mreq", int'(mreq), int'(strobe));
      if (strobe && px >= 28)
        chk((((px - 28) / 2) % 4 == 0) ? "R5 R6" : "R5 R7", "addr", int'(addr), exp_addr(line, px));
      else
        chk("R11", "addr idle", int'(addr), 0);
      if (!on || px < 38 || px > 277)
        chk(px > 277 ? "R9" : "R11", "pix dark", int'(pix), 0);
      else if (px >= pix_from)
        chk(px >= 270 ? "R9" : ptag, "pix", int'(pix), exp_pix(line, px));
    end
  endtask

  task automatic t_reset();
    en = 1'b1;
    grant = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "reset hsync", int'(hsync), 1);
    chk("R2", "reset busreq", int'(busreq), 0);
    chk("R11", "reset mreq", int'(mreq), 0);
    chk("R11", "reset addr", int'(addr), 0);
    chk("R11", "reset pix", int'(pix), 0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    #1;
  endtask

  task automatic t_full(input int line);
    en = 1'b1;
    grant = 1'b1;
    goto(line);
    walk(line, 0, 0, 0, "R8");
  endtask

  task automatic t_inactive();
    en = 1'b1;
    grant = 1'b1;
    goto(AL);
    walk(AL, 0, 0, 0, "R2");
  endtask

  task automatic t_disabled(input int line);
    goto((line + TL - 1) % TL);
    en = 1'b0;
    goto(line);
    walk(line, LP, LP, LP, "R2");
  endtask

  task automatic t_no_ack(input int line);
    en = 1'b1;
    grant = 1'b0;
    goto(line);
    walk(line, 0, LP, LP, "R11");
    grant = 1'b1;
  endtask

  task automatic t_late(input int line);
    grant = 1'b1;
    goto((line + TL - 1) % TL);
    en = 1'b0;
    goto(line);
    // R10: enable at 99, grant seen at 100, correct slivers from 118
    walk(line, 99, 100, 118, "R10");
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_full(0);
    t_full(9);
    t_inactive();
    t_disabled(2);
    t_no_ack(5);
    t_late(7);
    t_full(8);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule